// File: doc/BRIEF.md
# Byte-level I2C master sequencer

This block runs the master side of I2C transfers one byte at a time. Software programs a control word, a 10-bit target address and a byte count. The sequencer then drives a byte-level bus engine, which accepts four operations: start with address and direction, send a byte (and return the acknowledge), receive a byte, and stop. Only one operation is outstanding at a time, and each one ends with a one-cycle done pulse from the engine. Outgoing data is popped from a shared byte FIFO of depth four, and incoming data is pushed into the same FIFO.

A pass of the sequencer starts after a control write or a kick pulse. The kick pulse tells the sequencer that the FIFO has changed. It has two modes:
- In count mode, a working counter limits the transfer. When the counter expires, the sequencer optionally issues stop, reloads the counter, reports access-ready and drops the master bit.
- In repeat mode, the counter is ignored and the sequencer moves whatever the FIFO allows.

Status is reported to an interrupt unit as one-cycle event pulses: no-ack, access-ready, transmit-ready and receive-ready.

Top module: `i2c_byte_master`

## Requirements
- R1: A control write stores only the bits in mask 0xCF07, and the stored word is visible on `ctrl_q`. Bit meanings: 15 enable, 14 byte order, 10 master, 9 transmit, 2 repeat mode, 1 stop, 0 start.
- R2: Start begins a transfer when enable, master and start are all set. The sequencer issues a start operation (`bus_op`=0) with the held target address on `bus_addr` and `bus_rnw` equal to the inverse of the transmit bit. The start bit then clears itself. If the address is refused (`bus_ack`=0 at done), the sequencer pulses `ev_nack` and no transfer becomes active.
- R3: In count mode with transmit, bytes are popped and sent (`bus_op`=1) while acknowledge holds, the working count is nonzero and the FIFO is not empty. Bytes go out in FIFO order, and each send decrements `cnt_cur`.
- R4: When the working count is zero in count mode, the sequencer first issues stop (`bus_op`=3) if the stop bit is set. It then clears the stop bit, reloads `cnt_cur` from the programmed count, pulses `ev_ardy` and clears the master bit.
- R5: A count-mode transmit pass that stops with count nonzero, acknowledge held and the FIFO empty pulses `ev_xrdy`. It does not pulse `ev_ardy` and keeps the master bit set.
- R6: In count mode with receive, bytes are received (`bus_op`=2) and pushed while the count is nonzero and the FIFO holds fewer than 4 bytes. Each byte decrements the count, and `ev_rrdy` pulses once afterwards.
- R7: In repeat mode, a set stop bit makes the pass issue stop, clear the stop bit, reload the count and end the transfer, without `ev_ardy`.
- R8: In repeat mode, transmit drains the whole FIFO whatever the count, leaves `cnt_cur` unchanged and then pulses `ev_xrdy`. Receive takes exactly one byte and pulses `ev_rrdy`.
- R9: A send answered with no acknowledge ends the pass. It pulses `ev_nack`, clears the stop bit and sends no further bytes.
- R10: No send, receive or stop operation is issued while enable is clear or while no transfer is active; a kick then has no effect on the bus.
- R11: A request holds `bus_req` and a stable `bus_op` until `bus_done`; only one operation is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write data |
| sa_wr | input | 1 | Target address write strobe |
| sa_wdata | input | 10 | Target address |
| cnt_wr | input | 1 | Byte count write strobe (loads programmed and working count) |
| cnt_wdata | input | 16 | Byte count |
| kick | input | 1 | FIFO changed; run a sequencer pass |
| ctrl_q | output | 16 | Stored control word |
| sa_q | output | 10 | Stored target address |
| cnt_cur | output | 16 | Working byte count |
| fifo_level | input | 3 | Bytes held in the shared FIFO |
| fifo_rdata | input | 8 | Byte at the FIFO head |
| fifo_pop | output | 1 | Pop the FIFO head |
| fifo_push | output | 1 | Push `fifo_wdata` |
| fifo_wdata | output | 8 | Received byte |
| bus_req | output | 1 | Bus operation request |
| bus_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| bus_addr | output | 10 | Target address for start |
| bus_rnw | output | 1 | Direction for start, 1 = read |
| bus_wdata | output | 8 | Byte to send |
| bus_done | input | 1 | Operation finished (one cycle) |
| bus_ack | input | 1 | Acknowledge at done |
| bus_rdata | input | 8 | Received byte at done |
| ev_nack | output | 1 | No-ack event pulse |
| ev_ardy | output | 1 | Access-ready event pulse |
| ev_xrdy | output | 1 | Transmit-ready event pulse |
| ev_rrdy | output | 1 | Receive-ready event pulse |

## Verification
The hardest situation to reach from the ports is a missing acknowledge on a byte in the middle of a counted burst, with the stop bit set. To get there, the stimulus programs a count of four with four bytes queued, and the bus responder refuses only the second send. The check confirms that the pass stops at two sends, the count reads two, the stop bit clears and no stop or access-ready follows. A second hard case is a receive that fills the FIFO before the count expires. A count of six with an empty FIFO must stop at four bytes, with a working count of two and receive-ready but no access-ready.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int CW = 16,
  parameter int AW = 10,
  parameter int DW = 8,
  parameter int FD = 4,
  localparam int LW = $clog2(FD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [15:0]   ctrl_wdata,
  input  logic          sa_wr,
  input  logic [AW-1:0] sa_wdata,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          kick,
  output logic [15:0]   ctrl_q,
  output logic [AW-1:0] sa_q,
  output logic [CW-1:0] cnt_cur,
  input  logic [LW-1:0] fifo_level,
  input  logic [DW-1:0] fifo_rdata,
  output logic          fifo_pop,
  output logic          fifo_push,
  output logic [DW-1:0] fifo_wdata,
  output logic          bus_req,
  output logic [1:0]    bus_op,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rnw,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_done,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          ev_nack,
  output logic          ev_ardy,
  output logic          ev_xrdy,
  output logic          ev_rrdy
);

  localparam logic [15:0] KEEP = 16'hCF07;
  localparam int B_EN = 15, B_MST = 10, B_TRX = 9, B_RM = 2, B_STP = 1, B_STT = 0;
  localparam logic [1:0] OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_RUN, S_SEND, S_RECV, S_STOP, S_FIN} st_t;

  st_t           st;
  logic [CW-1:0] cnt_prog;
  logic          active_q, pend, ack_ok, got_rx, stop_fin;

  wire en      = ctrl_q[B_EN];
  wire master  = ctrl_q[B_MST];
  wire trx     = ctrl_q[B_TRX];
  wire rm      = ctrl_q[B_RM];
  wire stp     = ctrl_q[B_STP];
  wire fifo_mt = (fifo_level == '0);
  wire fifo_rm = (fifo_level < LW'(FD));
  wire cnt_nz  = (cnt_cur != '0);

  assign bus_addr = sa_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ctrl_q     <= '0;
      sa_q       <= '0;
      cnt_cur    <= '0;
      cnt_prog   <= '0;
      active_q   <= 1'b0;
      pend       <= 1'b0;
      ack_ok     <= 1'b1;
      got_rx     <= 1'b0;
      stop_fin   <= 1'b0;
      bus_req    <= 1'b0;
      bus_op     <= OP_START;
      bus_rnw    <= 1'b0;
      bus_wdata  <= '0;
      fifo_pop   <= 1'b0;
      fifo_push  <= 1'b0;
      fifo_wdata <= '0;
      ev_nack    <= 1'b0;
      ev_ardy    <= 1'b0;
      ev_xrdy    <= 1'b0;
      ev_rrdy    <= 1'b0;
    end else begin
      fifo_pop  <= 1'b0;
      fifo_push <= 1'b0;
      ev_nack   <= 1'b0;
      ev_ardy   <= 1'b0;
      ev_xrdy   <= 1'b0;
      ev_rrdy   <= 1'b0;

      case (st)
        S_IDLE: begin
          if (en && master && ctrl_q[B_STT]) begin
            bus_req <= 1'b1;
            bus_op  <= OP_START;
            bus_rnw <= ~trx;
            st      <= S_START;
          end else if (pend) begin
            pend <= 1'b0;
            if (en && master && active_q) begin
              ack_ok <= 1'b1;
              got_rx <= 1'b0;
              st     <= S_RUN;
            end
          end
        end

        S_START: if (bus_done) begin
          bus_req        <= 1'b0;
          ctrl_q[B_STT]  <= 1'b0;
          pend           <= 1'b0;
          if (bus_ack) begin
            active_q <= 1'b1;
            ack_ok   <= 1'b1;
            got_rx   <= 1'b0;
            st       <= S_RUN;
          end else begin
            active_q <= 1'b0;
            ev_nack  <= 1'b1;
            st       <= S_IDLE;
          end
        end

        S_RUN: begin
          if (!en || !master) begin
            st <= S_IDLE;
          end else if (rm) begin
            if (stp) begin
              bus_req  <= 1'b1;
              bus_op   <= OP_STOP;
              stop_fin <= 1'b0;
              st       <= S_STOP;
            end else if (trx) begin
              if (ack_ok && !fifo_mt) begin
                bus_req   <= 1'b1;
                bus_op    <= OP_SEND;
                bus_wdata <= fifo_rdata;
                fifo_pop  <= 1'b1;
                st        <= S_SEND;
              end else begin
                if (ack_ok) ev_xrdy <= 1'b1;
                else begin
                  ev_nack       <= 1'b1;
                  ctrl_q[B_STP] <= 1'b0;
                end
                st <= S_IDLE;
              end
            end else begin
              if (!got_rx && fifo_rm) begin
                bus_req <= 1'b1;
                bus_op  <= OP_RECV;
                st      <= S_RECV;
              end else begin
                if (got_rx) ev_rrdy <= 1'b1;
                st <= S_IDLE;
              end
            end
          end else if (trx) begin
            if (ack_ok && cnt_nz && !fifo_mt) begin
              bus_req   <= 1'b1;
              bus_op    <= OP_SEND;
              bus_wdata <= fifo_rdata;
              fifo_pop  <= 1'b1;
              st        <= S_SEND;
            end else if (!ack_ok) begin
              ev_nack       <= 1'b1;
              ctrl_q[B_STP] <= 1'b0;
              st            <= S_IDLE;
            end else if (cnt_nz) begin
              ev_xrdy <= 1'b1;
              st      <= S_IDLE;
            end else begin
              st <= S_FIN;
            end
          end else begin
            if (cnt_nz && fifo_rm) begin
              bus_req <= 1'b1;
              bus_op  <= OP_RECV;
              st      <= S_RECV;
            end else begin
              if (got_rx) ev_rrdy <= 1'b1;
              st <= cnt_nz ? S_IDLE : S_FIN;
            end
          end
        end

        S_SEND: if (bus_done) begin
          bus_req <= 1'b0;
          if (!rm) cnt_cur <= cnt_cur - 1'b1;
          if (!bus_ack) ack_ok <= 1'b0;
          st <= S_RUN;
        end

        S_RECV: if (bus_done) begin
          bus_req    <= 1'b0;
          fifo_push  <= 1'b1;
          fifo_wdata <= bus_rdata;
          got_rx     <= 1'b1;
          if (!rm) cnt_cur <= cnt_cur - 1'b1;
          st <= S_RUN;
        end

        S_FIN: begin
          if (stp) begin
            bus_req  <= 1'b1;
            bus_op   <= OP_STOP;
            stop_fin <= 1'b1;
            st       <= S_STOP;
          end else begin
            cnt_cur       <= cnt_prog;
            ev_ardy       <= 1'b1;
            ctrl_q[B_MST] <= 1'b0;
            st            <= S_IDLE;
          end
        end

        S_STOP: if (bus_done) begin
          bus_req       <= 1'b0;
          ctrl_q[B_STP] <= 1'b0;
          active_q      <= 1'b0;
          cnt_cur       <= cnt_prog;
          if (stop_fin) begin
            ev_ardy       <= 1'b1;
            ctrl_q[B_MST] <= 1'b0;
          end
          st <= S_IDLE;
        end

        default: st <= S_IDLE;
      endcase

      if (kick || ctrl_wr) pend <= 1'b1;
      if (sa_wr) sa_q <= sa_wdata;
      if (cnt_wr) begin
        cnt_prog <= cnt_wdata;
        cnt_cur  <= cnt_wdata;
      end
      if (ctrl_wr) ctrl_q <= ctrl_wdata & KEEP;
    end
  end

  // R1
  always_comb ctrl_mask_chk: assert ((ctrl_q & ~KEEP) == 16'h0);

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && bus_done && !ctrl_wr) |=> !ctrl_q[B_STT]);

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && bus_done && !rm && !cnt_wr) |=> cnt_cur == $past(cnt_cur) - 1'b1);

  // R4
  ardy_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ardy && !$past(ctrl_wr)) |-> !ctrl_q[B_MST]);

  // R10
  no_idle_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_req) && bus_op != OP_START) |-> ($past(ctrl_q[B_EN]) && $past(active_q)));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_op)));

  // R5
  xrdy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_xrdy && (ev_nack || ev_ardy)));

endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  logic        clk = 0, rst_n = 0;
  logic        ctrl_wr = 0, sa_wr = 0, cnt_wr = 0, kick = 0;
  logic [15:0] ctrl_wdata = 0, cnt_wdata = 0;
  logic [9:0]  sa_wdata = 0;
  logic [15:0] ctrl_q, cnt_cur;
  logic [9:0]  sa_q, bus_addr;
  logic [2:0]  fifo_level = 0;
  logic [7:0]  fifo_rdata = 0, fifo_wdata, bus_wdata, bus_rdata = 0;
  logic        fifo_pop, fifo_push, bus_req, bus_rnw, bus_done = 0, bus_ack = 0;
  logic [1:0]  bus_op;
  logic        ev_nack, ev_ardy, ev_xrdy, ev_rrdy;

  always #2 clk = ~clk;

  i2c_byte_master u0 (.*);

  int checks = 0, failures = 0;
  logic clr = 0, fl = 0, pc = 0;
  logic [7:0] pb = 0;
  logic nack_start = 0;
  int nack_at = -1;
  int n_start, n_send, n_recv, n_stop, c_nack, c_ardy, c_xrdy, c_rrdy;
  logic [9:0] last_addr;
  logic last_rnw;
  logic [7:0] q[$];
  logic [7:0] sent[$];
  logic busy = 0;
  int dly = 0;

  always @(negedge clk) begin
    if (clr) begin
      n_start = 0; n_send = 0; n_recv = 0; n_stop = 0;
      c_nack = 0; c_ardy = 0; c_xrdy = 0; c_rrdy = 0;
      sent.delete();
    end else begin
      if (ev_nack) c_nack++;
      if (ev_ardy) c_ardy++;
      if (ev_xrdy) c_xrdy++;
      if (ev_rrdy) c_rrdy++;
    end
    if (fl) q.delete();
    if (pc) q.push_back(pb);
    if (fifo_pop && q.size() > 0) void'(q.pop_front());
    if (fifo_push) q.push_back(fifo_wdata);
    if (bus_done) bus_done = 0;
    else if (busy) begin
      if (dly == 0) begin
        busy = 0;
        bus_done = 1;
        bus_ack = 1;
        case (bus_op)
          2'd0: begin n_start++; last_addr = bus_addr; last_rnw = bus_rnw; bus_ack = !nack_start; end
          2'd1: begin bus_ack = (n_send != nack_at); n_send++; sent.push_back(bus_wdata); end
          2'd2: begin bus_rdata = 8'hA0 + 8'(n_recv); n_recv++; end
          default: n_stop++;
        endcase
      end else dly--;
    end else if (bus_req) begin
      busy = 1;
      dly = 2;
    end
    fifo_level = 3'(q.size());
    fifo_rdata = (q.size() > 0) ? q[0] : 8'h00;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    clr = 1; fl = 1;
    @(negedge clk); #1;
    clr = 0; fl = 0;
  endtask

  task automatic push(logic [7:0] b);
    pc = 1; pb = b;
    @(negedge clk); #1;
    pc = 0;
  endtask

  task automatic wr_ctrl(logic [15:0] v);
    ctrl_wdata = v; ctrl_wr = 1; cyc(1); ctrl_wr = 0;
  endtask

  task automatic wr_cnt(logic [15:0] v);
    cnt_wdata = v; cnt_wr = 1; cyc(1); cnt_wr = 0;
  endtask

  // fields: cnt, nbytes, stop, exp_sent, exp_stops, exp_cnt, exp_ardy, exp_xrdy
  localparam logic [39:0] VEC [5] = '{
    {8'd2, 4'd2, 4'd1, 4'd2, 4'd1, 8'd2, 4'd1, 4'd0},
    {8'd3, 4'd1, 4'd1, 4'd1, 4'd0, 8'd2, 4'd0, 4'd1},
    {8'd1, 4'd3, 4'd0, 4'd1, 4'd0, 8'd1, 4'd1, 4'd0},
    {8'd4, 4'd4, 4'd1, 4'd4, 4'd1, 8'd4, 4'd1, 4'd0},
    {8'd0, 4'd2, 4'd1, 4'd0, 4'd1, 8'd0, 4'd1, 4'd0}
  };

  task automatic run_tests();
    cyc(3);
    rst_n = 1;
    cyc(2);
    chk("reset ctrl_q", ctrl_q, 0);
    chk("reset cnt_cur", cnt_cur, 0);
    chk("reset bus_req", bus_req, 0);

    clear_all();
    wr_ctrl(16'h7FFE);
    cyc(2);
    chk("R1 masked control word", ctrl_q, 16'h4F06);
    push(8'h11); push(8'h22);
    kick = 1; cyc(1); kick = 0;
    cyc(40);
    chk("R10 disabled: no bus ops", n_start + n_send + n_recv + n_stop, 0);

    clear_all();
    sa_wdata = 10'h2A5; sa_wr = 1; cyc(1); sa_wr = 0;
    nack_start = 1;
    push(8'h33); push(8'h44);
    wr_ctrl(16'h8601);
    cyc(40);
    nack_start = 0;
    chk("R2 one start", n_start, 1);
    chk("R2 start address", last_addr, 10'h2A5);
    chk("R2 direction write", last_rnw, 0);
    chk("R2 refused address nack", c_nack, 1);
    chk("R2 start bit cleared", ctrl_q[0], 0);
    chk("R2 no send after refusal", n_send, 0);
    kick = 1; cyc(1); kick = 0;
    cyc(40);
    chk("R10 inactive: kick sends nothing", n_send, 0);

    for (int i = 0; i < 5; i++) begin
      logic [39:0] v;
      int nb;
      int ok;
      v = VEC[i];
      clear_all();
      wr_cnt({8'h0, v[39:32]});
      nb = int'(v[31:28]);
      for (int k = 0; k < nb; k++) push(8'(16 * i + k + 1));
      wr_ctrl(16'h8601 | (v[27:24] != 0 ? 16'h0002 : 16'h0000));
      cyc(120);
      chk($sformatf("R3 vec%0d bytes sent", i), n_send, int'(v[23:20]));
      chk($sformatf("R4 vec%0d stop ops", i), n_stop, int'(v[19:16]));
      chk($sformatf("R4 vec%0d working count", i), cnt_cur, int'(v[15:8]));
      chk($sformatf("R4 vec%0d access-ready", i), c_ardy, int'(v[7:4]));
      chk($sformatf("R5 vec%0d transmit-ready", i), c_xrdy, int'(v[3:0]));
      chk($sformatf("R4 vec%0d master bit", i), ctrl_q[10], (v[7:4] == 0) ? 1 : 0);
      chk($sformatf("R4 vec%0d stop bit", i), ctrl_q[1],
          (v[27:24] != 0 && v[19:16] == 0) ? 1 : 0);
      ok = 1;
      for (int k = 0; k < sent.size(); k++)
        if (sent[k] != 8'(16 * i + k + 1)) ok = 0;
      chk($sformatf("R3 vec%0d byte order", i), ok, 1);
    end

    clear_all();
    wr_cnt(16'd3);
    wr_ctrl(16'h8401);
    cyc(120);
    chk("R2 direction read", last_rnw, 1);
    chk("R6 bytes received", n_recv, 3);
    chk("R6 fifo level", fifo_level, 3);
    chk("R6 first byte", (q.size() > 0) ? q[0] : 0, 8'hA0);
    chk("R6 receive-ready once", c_rrdy, 1);
    chk("R4 rx count reloaded", cnt_cur, 3);
    chk("R4 rx access-ready", c_ardy, 1);

    clear_all();
    wr_cnt(16'd6);
    wr_ctrl(16'h8401);
    cyc(120);
    chk("R6 stops at full fifo", n_recv, 4);
    chk("R6 remaining count", cnt_cur, 2);
    chk("R6 receive-ready", c_rrdy, 1);
    chk("R6 no access-ready", c_ardy, 0);

    clear_all();
    nack_at = 1;
    wr_cnt(16'd4);
    for (int k = 0; k < 4; k++) push(8'(8'h50 + k));
    wr_ctrl(16'h8603);
    cyc(120);
    nack_at = -1;
    chk("R9 sends stop at nack", n_send, 2);
    chk("R9 nack event", c_nack, 1);
    chk("R9 stop bit cleared", ctrl_q[1], 0);
    chk("R9 no stop op", n_stop, 0);
    chk("R9 count after nack", cnt_cur, 2);
    chk("R9 no access-ready", c_ardy, 0);

    clear_all();
    wr_cnt(16'd1);
    push(8'h61); push(8'h62); push(8'h63);
    wr_ctrl(16'h8605);
    cyc(120);
    chk("R8 repeat drains fifo", n_send, 3);
    chk("R8 count unchanged", cnt_cur, 1);
    chk("R8 transmit-ready", c_xrdy, 1);

    clear_all();
    wr_ctrl(16'h8606);
    cyc(60);
    chk("R7 repeat stop op", n_stop, 1);
    chk("R7 stop bit cleared", ctrl_q[1], 0);
    chk("R7 no access-ready", c_ardy, 0);
    chk("R7 count reloaded", cnt_cur, 1);
    chk("R7 no bytes sent", n_send, 0);

    clear_all();
    wr_ctrl(16'h8405);
    cyc(60);
    chk("R8 repeat rx one byte", n_recv, 1);
    chk("R8 repeat receive-ready", c_rrdy, 1);
    chk("R8 fifo holds one", fifo_level, 1);
  endtask

  initial begin
    bit timed_out;
    timed_out = 0;
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=1 exp=0");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule